// File: doc/BRIEF.md
# Shared Interrupt Controller

This block collects a bank of external interrupt lines and delivers them to several processor contexts. Each line is brought into the clock domain by a two-flop synchronizer. It then sets a pending bit according to its own sense settings: level or edge, active-high or active-low, and optionally both edges. A pending line raises the interrupt output of its context when it is enabled. Each line is routed to exactly one context.

Software drives the block over a simple 32-bit register bus with byte addresses. Registers that hold one bit per source pack 32 sources into each word, and successive words sit 4 bytes apart. Enables are changed through separate write-one-to-enable and write-one-to-disable words, so no read-modify-write is needed. A single software edge word can inject an interrupt on an edge-sensed source or acknowledge one. The number of sources is eight times a parameter, and a read-only information word reports it.

Top module: `shic_top`

## Requirements
- R1: The aligned word at address 0x000 reads as bits [7:0] = NUM_GROUPS-1 (source count = (field+1)*8) and bits [15:8] = NUM_CTX-1, with the other bits 0.
- R2: After reset every source is disabled, active-high (sense word bit = 1), level-sensed (trigger bit = 0), single-edge (dual bit = 0) and routed to context 0, and every interrupt output is 0.
- R3: A level-sensed source's pending bit equals its input XOR NOT(polarity bit). It is updated on the third rising clock edge after the input changes. Pending reads at 0x100 + 4*w, where bit b is source 32*w+b.
- R4: Writing 0x200 + 4*w sets the enable of every source whose data bit is 1, and writing 0x280 + 4*w clears it. Data bits that are 0 leave the enable unchanged. Enables read at 0x180 + 4*w.
- R5: An edge-sensed source (trigger bit 1 at 0x380 + 4*w) with dual bit 0 becomes pending on a rising input when its polarity bit (0x300 + 4*w) is 1, and on a falling input when it is 0. The bit stays pending after the input returns.
- R6: When the dual bit (0x400 + 4*w) of an edge-sensed source is 1, both input transitions set pending and the polarity bit has no effect.
- R7: A write to 0x004 with bit 31 = 1 sets the pending bit of the edge-sensed source whose index is in bits [30:0]. Bit 31 = 0 clears it. An index at or above the source count, or a level-sensed target, leaves every pending bit unchanged. The change is visible from the clock edge that takes the write.
- R8: The route word of source i is at 0x800 + 4*i. A write with any of bits [NUM_CTX-1:0] set selects the lowest such bit's context, a write with none of them set is ignored, and a read returns the selected context as a one-hot value.
- R9: Interrupt output c is 1 exactly when some source is pending, enabled and routed to context c. It follows enable and route changes from the clock edge that takes the write.
- R10: Read data appears on the bus data output one clock edge after the read is taken and holds until the next read. An aligned address that maps to no register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_GROUPS*8 | Asynchronous interrupt source lines |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [1:0] must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CTX | One interrupt request per context |

## Verification
A source change moves through two synchronizer flops and the pending register, so its effect is due on the third rising edge after the input is driven. The bench drives inputs on a falling edge and then waits exactly three rising edges plus a falling edge before it samples. Enable, route and software-edge writes act at the edge that takes them, so the bench checks their effect at the falling edge right after the write. Read data is registered and is sampled one falling edge after the read is presented.

// File: rtl/shic_pkg.sv
package shic_pkg;

    localparam int unsigned BUS_AW = 12;

    // address regions, selected by bus_addr[11:8]
    localparam logic [3:0] RG_CTL    = 4'h0;
    localparam logic [3:0] RG_STAT   = 4'h1;
    localparam logic [3:0] RG_MASKOP = 4'h2;
    localparam logic [3:0] RG_SENSE  = 4'h3;
    localparam logic [3:0] RG_DUAL   = 4'h4;

    localparam logic [BUS_AW-1:0] ADDR_INFO   = 12'h000;
    localparam logic [BUS_AW-1:0] ADDR_SWEDGE = 12'h004;

    typedef struct packed {
        logic dual;
        logic trig;
        logic pol;
    } sense_cfg_t;

    typedef struct packed {
        logic       en_wr;
        logic       en_rd;
        logic [3:0] region;
        logic       upper;
        logic [4:0] widx;
        logic       is_route;
        logic [8:0] ridx;
    } bus_dec_t;

    function automatic bus_dec_t decode_bus(input logic en, input logic wr,
                                            input logic [BUS_AW-1:0] a);
        bus_dec_t d;
        logic     aligned;
        aligned    = (a[1:0] == 2'b00);
        d.en_wr    = en && wr && aligned;
        d.en_rd    = en && !wr && aligned;
        d.region   = a[11:8];
        d.upper    = a[7];
        d.widx     = a[6:2];
        d.is_route = a[11];
        d.ridx     = a[10:2];
        return d;
    endfunction

    function automatic int unsigned first_one(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int k = 31; k >= 0; k--) begin
            if (v[k]) r = k;
        end
        return r;
    endfunction

    function automatic logic [31:0] info_word(input int unsigned groups,
                                              input int unsigned ctx);
        return {16'h0000, 8'(ctx - 1), 8'(groups - 1)};
    endfunction

endpackage

// File: rtl/shic_src_cell.sv
module shic_src_cell
    import shic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw_i,
    input  sense_cfg_t cfg_i,
    input  logic       sw_set_i,
    input  logic       sw_clr_i,
    output logic       pend_o
);

    logic meta_q, sync_q, prev_q, pend_q;
    logic edge_hit, level_val;

    always_comb begin
        level_val = cfg_i.pol ? sync_q : ~sync_q;
        if (cfg_i.dual)
            edge_hit = sync_q ^ prev_q;
        else if (cfg_i.pol)
            edge_hit = sync_q & ~prev_q;
        else
            edge_hit = ~sync_q & prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (!cfg_i.trig)
                pend_q <= level_val;
            else if (edge_hit || sw_set_i)
                pend_q <= 1'b1;
            else if (sw_clr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/shic_regs.sv
module shic_regs
    import shic_pkg::*;
#(
    parameter  int unsigned NUM_GROUPS = 8,
    parameter  int unsigned NUM_CTX    = 4,
    localparam int unsigned NUM_SRC    = NUM_GROUPS * 8,
    localparam int unsigned CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
)(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_en,
    input  logic                              bus_wr,
    input  logic [BUS_AW-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    input  logic [NUM_SRC-1:0]                pend_i,
    output logic [31:0]                       rdata_o,
    output logic [NUM_SRC-1:0]                mask_o,
    output sense_cfg_t [NUM_SRC-1:0]          cfg_o,
    output logic [NUM_SRC-1:0][CTX_W-1:0]     route_o,
    output logic [NUM_SRC-1:0]                sw_set_o,
    output logic [NUM_SRC-1:0]                sw_clr_o
);

    localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32;
    localparam int unsigned WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int unsigned RSEL_W    = $clog2(NUM_SRC);

    bus_dec_t dec;
    logic word_ok, route_ok;
    logic we_smask, we_rmask, we_pol, we_trig, we_dual, we_route, sw_hit;
    logic [WSEL_W-1:0] wsel;
    logic [RSEL_W-1:0] rsel;
    logic [31:0] rd_word, rdata_q;

    logic [NUM_SRC-1:0]            mask_q;
    sense_cfg_t [NUM_SRC-1:0]      cfg_q;
    logic [NUM_SRC-1:0][CTX_W-1:0] route_q;

    logic [NUM_WORDS-1:0][31:0] pend_a, mask_a, pol_a, trig_a, dual_a;

    assign dec      = decode_bus(bus_en, bus_wr, bus_addr);
    assign word_ok  = int'(dec.widx) < NUM_WORDS;
    assign route_ok = int'(dec.ridx) < NUM_SRC;
    assign wsel     = dec.widx[WSEL_W-1:0];
    assign rsel     = dec.ridx[RSEL_W-1:0];

    assign we_smask = dec.en_wr && !dec.is_route && dec.region == RG_MASKOP && !dec.upper && word_ok;
    assign we_rmask = dec.en_wr && !dec.is_route && dec.region == RG_MASKOP &&  dec.upper && word_ok;
    assign we_pol   = dec.en_wr && !dec.is_route && dec.region == RG_SENSE  && !dec.upper && word_ok;
    assign we_trig  = dec.en_wr && !dec.is_route && dec.region == RG_SENSE  &&  dec.upper && word_ok;
    assign we_dual  = dec.en_wr && !dec.is_route && dec.region == RG_DUAL   && !dec.upper && word_ok;
    assign we_route = dec.en_wr && dec.is_route && route_ok && (|bus_wdata[NUM_CTX-1:0]);
    assign sw_hit   = dec.en_wr && bus_addr == ADDR_SWEDGE;

    // software edge decode: one strobe per source
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            sw_set_o[i] = sw_hit &&  bus_wdata[31] && int'(bus_wdata[30:0]) == i;
            sw_clr_o[i] = sw_hit && !bus_wdata[31] && int'(bus_wdata[30:0]) == i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            route_q <= '0;
            rdata_q <= '0;
            for (int i = 0; i < NUM_SRC; i++)
                cfg_q[i] <= '{dual: 1'b0, trig: 1'b0, pol: 1'b1};
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (int'(dec.widx) == i / 32) begin
                    if (we_smask && bus_wdata[i % 32]) mask_q[i] <= 1'b1;
                    if (we_rmask && bus_wdata[i % 32]) mask_q[i] <= 1'b0;
                    if (we_pol)  cfg_q[i].pol  <= bus_wdata[i % 32];
                    if (we_trig) cfg_q[i].trig <= bus_wdata[i % 32];
                    if (we_dual) cfg_q[i].dual <= bus_wdata[i % 32];
                end
                if (we_route && int'(dec.ridx) == i)
                    route_q[i] <= CTX_W'(first_one(32'(bus_wdata[NUM_CTX-1:0])));
            end
            if (dec.en_rd)
                rdata_q <= rd_word;
        end
    end

    // word views of the per-source bits, padded with zeros
    for (genvar b = 0; b < NUM_WORDS * 32; b++) begin : g_pack
        if (b < NUM_SRC) begin : g_live
            assign pend_a[b / 32][b % 32] = pend_i[b];
            assign mask_a[b / 32][b % 32] = mask_q[b];
            assign pol_a[b / 32][b % 32]  = cfg_q[b].pol;
            assign trig_a[b / 32][b % 32] = cfg_q[b].trig;
            assign dual_a[b / 32][b % 32] = cfg_q[b].dual;
        end else begin : g_pad
            assign pend_a[b / 32][b % 32] = 1'b0;
            assign mask_a[b / 32][b % 32] = 1'b0;
            assign pol_a[b / 32][b % 32]  = 1'b0;
            assign trig_a[b / 32][b % 32] = 1'b0;
            assign dual_a[b / 32][b % 32] = 1'b0;
        end
    end

    always_comb begin
        rd_word = '0;
        if (dec.is_route) begin
            if (route_ok) rd_word = 32'(1) << route_q[rsel];
        end else begin
            case (dec.region)
                RG_CTL:   if (bus_addr == ADDR_INFO) rd_word = info_word(NUM_GROUPS, NUM_CTX);
                RG_STAT:  if (word_ok) rd_word = dec.upper ? mask_a[wsel] : pend_a[wsel];
                RG_SENSE: if (word_ok) rd_word = dec.upper ? trig_a[wsel] : pol_a[wsel];
                RG_DUAL:  if (word_ok && !dec.upper) rd_word = dual_a[wsel];
                default:  rd_word = '0;
            endcase
        end
    end

    assign rdata_o = rdata_q;
    assign mask_o  = mask_q;
    assign cfg_o   = cfg_q;
    assign route_o = route_q;

endmodule

// File: rtl/shic_ctx_or.sv
module shic_ctx_or #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CTX = 4,
    parameter int unsigned CTX_W   = 2
)(
    input  logic [NUM_SRC-1:0]            pend_i,
    input  logic [NUM_SRC-1:0]            mask_i,
    input  logic [NUM_SRC-1:0][CTX_W-1:0] route_i,
    output logic [NUM_CTX-1:0]            irq_o
);

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic [NUM_SRC-1:0] sel;
        always_comb begin
            for (int i = 0; i < NUM_SRC; i++)
                sel[i] = pend_i[i] & mask_i[i] & (route_i[i] == CTX_W'(c));
        end
        assign irq_o[c] = |sel;
    end

endmodule

// File: rtl/shic_top.sv
module shic_top
    import shic_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned NUM_CTX    = 4
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_GROUPS*8-1:0] src_in,
    input  logic                    bus_en,
    input  logic                    bus_wr,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NUM_CTX-1:0]      irq_out
);

    localparam int unsigned NUM_SRC = NUM_GROUPS * 8;
    localparam int unsigned CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    logic [NUM_SRC-1:0]            pend_q, mask_q, sw_set, sw_clr, trig_v;
    sense_cfg_t [NUM_SRC-1:0]      cfg_q;
    logic [NUM_SRC-1:0][CTX_W-1:0] route_q;

    shic_regs #(.NUM_GROUPS(NUM_GROUPS), .NUM_CTX(NUM_CTX)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_en   (bus_en),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pend_i   (pend_q),
        .rdata_o  (bus_rdata),
        .mask_o   (mask_q),
        .cfg_o    (cfg_q),
        .route_o  (route_q),
        .sw_set_o (sw_set),
        .sw_clr_o (sw_clr)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        shic_src_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (src_in[i]),
            .cfg_i   (cfg_q[i]),
            .sw_set_i(sw_set[i]),
            .sw_clr_i(sw_clr[i]),
            .pend_o  (pend_q[i])
        );
        assign trig_v[i] = cfg_q[i].trig;
    end

    shic_ctx_or #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_ctx (
        .pend_i (pend_q),
        .mask_i (mask_q),
        .route_i(route_q),
        .irq_o  (irq_out)
    );

endmodule

// File: rtl/shic_chk.sv
module shic_chk #(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned NUM_CTX    = 4
)(
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_en,
    input logic                    bus_wr,
    input logic [11:0]             bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [NUM_CTX-1:0]      irq_out,
    input logic [NUM_GROUPS*8-1:0] pend,
    input logic [NUM_GROUPS*8-1:0] mask,
    input logic [NUM_GROUPS*8-1:0] trig
);

    localparam int unsigned NUM_SRC = NUM_GROUPS * 8;
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);

    logic             bus_w, sw_set_ev, sw_clr0_ev;
    logic [IDX_W-1:0] sw_idx;

    assign bus_w      = bus_en && bus_wr;
    assign sw_idx     = bus_wdata[IDX_W-1:0];
    assign sw_set_ev  = bus_w && bus_addr == 12'h004 && bus_wdata[31]
                        && (bus_wdata[30:0] < 31'(NUM_SRC)) && trig[sw_idx];
    assign sw_clr0_ev = bus_w && bus_addr == 12'h004 && !bus_wdata[31]
                        && bus_wdata[30:0] == 31'd0;

    p_info_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && bus_addr == 12'h000) |=>
            bus_rdata == {16'h0000, 8'(NUM_CTX - 1), 8'(NUM_GROUPS - 1)});

    p_reset_quiet_r2: assert property (@(posedge clk)
        rst |=> (irq_out == '0 && mask == '0));

    p_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_w && bus_addr == 12'h200 && bus_wdata[0]) |=> mask[0]);

    p_mask_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_w && bus_addr == 12'h280 && bus_wdata[0]) |=> !mask[0]);

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (trig[0] && pend[0] && !sw_clr0_ev) |=> pend[0]);

    p_sw_raise_r7: assert property (@(posedge clk) disable iff (rst)
        sw_set_ev |=> pend[$past(sw_idx)]);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> ((pend & mask) != '0));

endmodule

bind shic_top shic_chk #(.NUM_GROUPS(NUM_GROUPS), .NUM_CTX(NUM_CTX)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .pend     (pend_q),
    .mask     (mask_q),
    .trig     (trig_v)
);

// File: tb/tb_shic_top.sv
module tb_shic_top;

    localparam int NUM_GROUPS = 8;
    localparam int NUM_CTX    = 4;
    localparam int NUM_SRC    = NUM_GROUPS * 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] src_in = '0;
    logic               bus_en = 1'b0;
    logic               bus_wr = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_CTX-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    shic_top #(.NUM_GROUPS(NUM_GROUPS), .NUM_CTX(NUM_CTX)) dut (
        .clk(clk), .rst(rst), .src_in(src_in),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    // input driven at a falling edge is due in pending on the third rising edge
    task automatic wait_sync();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_pend(input string req, input logic [63:0] exp);
        logic [31:0] d;
        rd(12'h100, d); check(req, d, exp[31:0]);
        rd(12'h104, d); check(req, d, exp[63:32]);
    endtask

    task automatic clear_all_sw();
        for (int i = 0; i < NUM_SRC; i++) wr(12'h004, 32'(i));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [63:0] exp;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        check("R2 irq", 32'(irq_out), 32'h0);
        rd(12'h180, d); check("R2 mask w0", d, 32'h0);
        rd(12'h184, d); check("R2 mask w1", d, 32'h0);
        rd(12'h300, d); check("R2 pol w0", d, 32'hffffffff);
        rd(12'h304, d); check("R2 pol w1", d, 32'hffffffff);
        rd(12'h380, d); check("R2 trig", d, 32'h0);
        rd(12'h400, d); check("R2 dual", d, 32'h0);
        rd(12'h814, d); check("R2 route", d, 32'h1);
        rd(12'h8fc, d); check("R2 route last", d, 32'h1);
        // R1, R10
        rd(12'h000, d); check("R1 info", d, 32'h0000_0307);
        rd(12'h7fc, d); check("R10 unmapped", d, 32'h0);
        rd(12'h008, d); check("R10 unmapped ctl", d, 32'h0);

        // R3: level sweep, active-high
        wr(12'h200, 32'hffffffff);
        wr(12'h204, 32'hffffffff);
        for (int i = 0; i < NUM_SRC; i++) begin
            src_in = 64'(1) << i;
            wait_sync();
            check("R3 level irq", 32'(irq_out), 32'h1);
            check_pend("R3 level high", 64'(1) << i);
        end
        src_in = '0;
        wait_sync();
        check("R3 level idle irq", 32'(irq_out), 32'h0);
        // R3: active-low
        wr(12'h300, 32'h0);
        wr(12'h304, 32'h0);
        wait_sync();
        check_pend("R3 level low idle", {64{1'b1}});
        src_in = '1;
        wait_sync();
        check_pend("R3 level low driven", 64'h0);
        wr(12'h300, 32'hffffffff);
        wr(12'h304, 32'hffffffff);
        wait_sync();
        check_pend("R3 restored", {64{1'b1}});

        // R4: write-one enables
        wr(12'h280, 32'hffffffff);
        wr(12'h284, 32'hffffffff);
        check("R9 all masked", 32'(irq_out), 32'h0);
        rd(12'h180, d); check("R4 cleared", d, 32'h0);
        wr(12'h200, 32'ha5a5a5a5);
        wr(12'h204, 32'h0000ffff);
        check("R9 some enabled", 32'(irq_out), 32'h1);
        wr(12'h280, 32'h000000ff);
        wr(12'h200, 32'h0);
        wr(12'h284, 32'h0);
        rd(12'h180, d); check("R4 mask w0", d, 32'ha5a5a500);
        rd(12'h184, d); check("R4 mask w1", d, 32'h0000ffff);
        wr(12'h280, 32'hffffffff);
        wr(12'h284, 32'hffffffff);

        // R8/R9: route every source, enable one at a time
        for (int i = 0; i < NUM_SRC; i++)
            wr(12'h800 + 12'(4 * i), 32'(1) << (i % NUM_CTX));
        rd(12'h818, d); check("R8 route readback", d, 32'h4);
        for (int i = 0; i < NUM_SRC; i++) begin
            wr(12'h200 + 12'(4 * (i / 32)), 32'(1) << (i % 32));
            check("R9 single ctx", 32'(irq_out), 32'(1) << (i % NUM_CTX));
            wr(12'h280 + 12'(4 * (i / 32)), 32'(1) << (i % 32));
        end
        wr(12'h828, 32'hc);
        rd(12'h828, d); check("R8 lowest bit", d, 32'h4);
        wr(12'h828, 32'h0);
        rd(12'h828, d); check("R8 zero ignored", d, 32'h4);
        wr(12'h200, 32'h0000_0406);
        check("R9 ctx mix", 32'(irq_out), 32'h6);

        // R5: single-edge sensing, word 0 rising, word 1 falling
        wr(12'h200, 32'hffffffff);
        wr(12'h204, 32'hffffffff);
        src_in = '0;
        wait_sync();
        wr(12'h380, 32'hffffffff);
        wr(12'h384, 32'hffffffff);
        wr(12'h304, 32'h0);
        check_pend("R5 armed", 64'h0);
        src_in = '1;
        wait_sync();
        check_pend("R5 rise", {32'h0, 32'hffffffff});
        src_in = '0;
        wait_sync();
        check_pend("R5 fall held", {64{1'b1}});
        for (int i = 0; i < 32; i++) wr(12'h004, 32'(i));
        check_pend("R7 partial clear", {32'hffffffff, 32'h0});
        for (int i = 32; i < NUM_SRC; i++) wr(12'h004, 32'(i));
        check_pend("R7 full clear", 64'h0);
        check("R7 irq after clear", 32'(irq_out), 32'h0);

        // R6: dual edge on low half of word 0, word 0 polarity falling
        wr(12'h400, 32'h0000ffff);
        wr(12'h300, 32'h0);
        src_in = '1;
        wait_sync();
        check_pend("R6 rise", {32'h0, 32'h0000ffff});
        clear_all_sw();
        src_in = '0;
        wait_sync();
        check_pend("R6 fall", {64{1'b1}});
        clear_all_sw();
        check_pend("R6 cleared", 64'h0);

        // R7: software edge
        wr(12'h004, 32'h8000_0003);
        check("R7 set irq", 32'(irq_out), 32'h8);
        check_pend("R7 set", 64'h8);
        wr(12'h004, 32'h8000_0040);
        wr(12'h004, 32'h8000_1005);
        check_pend("R7 out of range", 64'h8);
        wr(12'h304, 32'hffffffff);
        wr(12'h384, 32'h0);
        wr(12'h004, 32'h8000_0028);
        exp = 64'h8;
        check_pend("R7 level ignored", exp);
        wr(12'h004, 32'h0000_0003);
        check("R7 clear irq", 32'(irq_out), 32'h0);
        check_pend("R7 clear", 64'h0);

        finish_run();
    end

endmodule